// File: doc/BRIEF.md
# Busy-cycle load monitor

This block estimates how heavily an engine is used by pairing two cycle counters. Counter 0 normally runs in "always" mode and counts every clock. Counter 1 normally runs in "busy" mode and counts only the clocks in which at least one engine busy input, selected by its mask, is high. A typical setup ORs the graphics engine with one copy engine. A threshold on each counter feeds a sticky overflow status bit. That bit can raise an interrupt, or it can simply be polled.

A frequency governor pulses `sample_req` at a steady rate. On an accepted sample, both counts and the overflow status are captured on the same clock edge. Both counters then restart, and the status bit is cleared. A restoring divider then computes busy × 1000 / total with truncation. The result saturates at 1000 when an overflow was seen, when the total count is zero, or when the busy count is larger than the total count. The divider has a fixed latency. When it finishes, it raises `load_valid` for one cycle, and the result stays on `load_out`.

Configuration goes through a word-addressed read/write port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `busy_load_monitor`

## Requirements
- R1: Each counter has a mode in bits [1:0] of its control word. In mode 01 ("always") it adds one on every clock. In mode 10 ("busy") it adds one only when `busy_in & mask` is non-zero. In modes 00 and 11 it holds its value. After reset, both counters are in mode 00 with a mask of zero.
- R2: Register map: counter i (0 = total, 1 = busy) owns words 4i+0 (control), 4i+1 (mask), 4i+2 (threshold, CNT_W-1 bits) and 4i+3 (count). Writing the count word with bit 0 = 1 restarts that counter; the increment of that same cycle is kept. Writing the count word with bit 0 = 0 has no effect. A counter stays at its all-ones value instead of wrapping.
- R3: Status bit 0 (word 9) is set on every edge at which some counter value is greater than or equal to its threshold. Once set, it stays set until it is cleared.
- R4: Writing word 9 with bit 0 = 1 clears the status bit. Writing it with bit 0 = 0 has no effect.
- R5: `irq` is high exactly when the status bit is set and the enable bit (word 8, bit 0) is 1. With the enable at 0, the status can only be polled.
- R6: A sample is accepted on an edge where `sample_req` is high and the divider is idle. On that edge the busy count, the total count and the status are captured together. Both counters restart with that cycle's increment, and the status bit is cleared.
- R7: The load equals 1000 if the captured status was set, if the total count is 0, or if the busy count is greater than the total count. Otherwise it equals floor(busy × 1000 / total).
- R8: `load_valid` is a single-cycle pulse that rises CNT_W+10 edges after the accepting edge. `load_out` and word 10 then hold the result until the next result arrives.
- R9: `sample_req` has no effect while the divider is busy: the counters keep counting and no extra result is produced.
- R10: Reset values: every count is 0, every threshold is all ones, both enable and status are 0, and `load_out` and `load_valid` are 0.
- R11: Control bit 2 (the filter option, where 0 means filtering is disabled) reads back as written and does not change counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_in | input | NUM_ENG | Per-engine busy indications |
| sample_req | input | 1 | Request to capture, restart and normalise |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| load_out | output | 10 | Last normalised load, 0 to 1000 |
| load_valid | output | 1 | One-cycle pulse when a new load is ready |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that `busy_in`, `sample_req` and the register strobes are synchronous and settle between edges. They also assume that a sample request and a status write may land on the same edge, in which case the clear still wins over the old status. The bench drives every input on the falling edge. It issues its timed samples only when its own model of the divider says the divider is idle. Extra requests are placed inside the divide window on purpose, so that the ignore rule is exercised.

// File: rtl/blm_pkg.sv
package blm_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'b00,
        MODE_ALWAYS = 2'b01,
        MODE_BUSY   = 2'b10,
        MODE_HOLD2  = 2'b11
    } cnt_mode_e;

    localparam int LOAD_MAX   = 1000;
    localparam int LOAD_W     = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam int CNT_NUM    = 2;
    localparam int TOTAL_IDX  = 0;
    localparam int BUSY_IDX   = 1;
    localparam int REG_STRIDE = 4;
    localparam int OFS_CTRL   = 0;
    localparam int OFS_MASK   = 1;
    localparam int OFS_THR    = 2;
    localparam int OFS_CNT    = 3;
    localparam int REG_IRQ_EN = 8;
    localparam int REG_STATUS = 9;
    localparam int REG_LOAD   = 10;
endpackage

// File: rtl/blm_counter.sv
module blm_counter
    import blm_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_ENG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENG-1:0] busy_in,
    input  logic               wr_ctrl,
    input  logic               wr_mask,
    input  logic               wr_thr,
    input  logic               wr_cnt,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               restart,
    output logic [CNT_W-1:0]   count_o,
    output logic [2:0]         ctrl_o,
    output logic [NUM_ENG-1:0] mask_o,
    output logic [CNT_W-2:0]   thr_o,
    output logic               thr_hit_o
);
    localparam int THR_W = CNT_W - 1;

    typedef struct packed {
        cnt_mode_e          mode;
        logic               filt;
        logic [NUM_ENG-1:0] mask;
        logic [THR_W-1:0]   thr;
        logic [CNT_W-1:0]   cnt;
    } cnt_state_t;

    localparam cnt_state_t CNT_RST = '{mode: MODE_HOLD, filt: 1'b0,
                                       mask: '0, thr: '1, cnt: '0};

    cnt_state_t s_d, s_q;
    logic       inc_d;
    logic       clr_d;
    logic       wdata_unused;

    assign wdata_unused = ^wdata;

    always_comb begin
        s_d = s_q;
        case (s_q.mode)
            MODE_ALWAYS: inc_d = 1'b1;
            MODE_BUSY:   inc_d = |(busy_in & s_q.mask);
            default:     inc_d = 1'b0;
        endcase
        clr_d = restart | (wr_cnt & wdata[0]);
        if (clr_d) begin
            s_d.cnt = {{(CNT_W-1){1'b0}}, inc_d};
        end else if (inc_d && !(&s_q.cnt)) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
        if (wr_ctrl) begin
            s_d.mode = cnt_mode_e'(wdata[1:0]);
            s_d.filt = wdata[2];
        end
        if (wr_mask) begin
            s_d.mask = wdata[NUM_ENG-1:0];
        end
        if (wr_thr) begin
            s_d.thr = wdata[THR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CNT_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o   = s_q.cnt;
    assign ctrl_o    = {s_q.filt, s_q.mode};
    assign mask_o    = s_q.mask;
    assign thr_o     = s_q.thr;
    assign thr_hit_o = s_q.cnt >= {1'b0, s_q.thr};

    // R1: a hold mode freezes the count unless a restart comes in
    a_r1_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == MODE_HOLD || s_q.mode == MODE_HOLD2) && !restart && !wr_cnt)
        |=> $stable(count_o));

    // R2: after a restart the count is at most the single carried increment
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count_o <= CNT_W'(1)));

    // R2: an all-ones count does not wrap
    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((&count_o) && !restart && !wr_cnt) |=> (&count_o));
endmodule

// File: rtl/blm_divider.sv
module blm_divider
    import blm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  busy_cnt,
    input  logic [CNT_W-1:0]  total_cnt,
    input  logic              ovf,
    output logic [LOAD_W-1:0] load_o,
    output logic              valid_o,
    output logic              busy_o
);
    localparam int NUM_W  = CNT_W + LOAD_W;
    localparam int ITER_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic              busy;
        logic              valid;
        logic              force_max;
        logic [ITER_W-1:0] iter;
        logic [NUM_W-1:0]  num;
        logic [CNT_W-1:0]  den;
        logic [CNT_W-1:0]  rem;
        logic [LOAD_W-1:0] quo;
        logic [LOAD_W-1:0] load;
    } div_state_t;

    div_state_t        s_d, s_q;
    logic [CNT_W:0]    rem_sh_d;
    logic              fits_d;
    logic [LOAD_W-1:0] quo_nx_d;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        rem_sh_d  = {s_q.rem, s_q.num[NUM_W-1]};
        fits_d    = rem_sh_d >= {1'b0, s_q.den};
        quo_nx_d  = {s_q.quo[LOAD_W-2:0], fits_d};
        if (s_q.busy) begin
            s_d.num  = {s_q.num[NUM_W-2:0], 1'b0};
            s_d.quo  = quo_nx_d;
            s_d.rem  = fits_d ? CNT_W'(rem_sh_d - {1'b0, s_q.den}) : CNT_W'(rem_sh_d);
            s_d.iter = s_q.iter - ITER_W'(1);
            if (s_q.iter == ITER_W'(1)) begin
                s_d.busy  = 1'b0;
                s_d.valid = 1'b1;
                s_d.load  = s_q.force_max ? LOAD_W'(LOAD_MAX) : quo_nx_d;
            end
        end else if (start) begin
            s_d.busy      = 1'b1;
            s_d.iter      = ITER_W'(NUM_W);
            s_d.num       = NUM_W'(busy_cnt) * NUM_W'(LOAD_MAX);
            s_d.den       = total_cnt;
            s_d.rem       = '0;
            s_d.quo       = '0;
            s_d.force_max = ovf || (total_cnt == '0) || (busy_cnt > total_cnt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load_o  = s_q.load;
    assign valid_o = s_q.valid;
    assign busy_o  = s_q.busy;

    // R8: the ready strobe lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: a finished result never exceeds the full-scale value
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (load_o <= LOAD_W'(LOAD_MAX)));

    // R9: once started, a new start cannot cut the divide short
    a_r9_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.iter > ITER_W'(1)) |=> busy_o);
endmodule

// File: rtl/busy_load_monitor.sv
module busy_load_monitor
    import blm_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_ENG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENG-1:0] busy_in,
    input  logic               sample_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [LOAD_W-1:0]  load_out,
    output logic               load_valid,
    output logic               irq
);
    typedef struct packed {
        logic irq_en;
        logic status;
    } top_state_t;

    top_state_t         s_d, s_q;
    logic               div_busy;
    logic               accept;
    logic               w1c;
    logic [CNT_NUM-1:0] thr_hit;
    logic [CNT_W-1:0]   cnt_v  [CNT_NUM];
    logic [2:0]         ctrl_v [CNT_NUM];
    logic [NUM_ENG-1:0] mask_v [CNT_NUM];
    logic [CNT_W-2:0]   thr_v  [CNT_NUM];

    assign accept = sample_req & ~div_busy;
    assign w1c    = reg_we && (reg_addr == ADDR_W'(REG_STATUS)) && reg_wdata[0];

    for (genvar g = 0; g < CNT_NUM; g++) begin : g_cnt
        localparam int BASE = g * REG_STRIDE;
        blm_counter #(.CNT_W(CNT_W), .NUM_ENG(NUM_ENG)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .busy_in   (busy_in),
            .wr_ctrl   (reg_we && (reg_addr == ADDR_W'(BASE + OFS_CTRL))),
            .wr_mask   (reg_we && (reg_addr == ADDR_W'(BASE + OFS_MASK))),
            .wr_thr    (reg_we && (reg_addr == ADDR_W'(BASE + OFS_THR))),
            .wr_cnt    (reg_we && (reg_addr == ADDR_W'(BASE + OFS_CNT))),
            .wdata     (reg_wdata),
            .restart   (accept),
            .count_o   (cnt_v[g]),
            .ctrl_o    (ctrl_v[g]),
            .mask_o    (mask_v[g]),
            .thr_o     (thr_v[g]),
            .thr_hit_o (thr_hit[g])
        );
    end

    blm_divider #(.CNT_W(CNT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .busy_cnt  (cnt_v[BUSY_IDX]),
        .total_cnt (cnt_v[TOTAL_IDX]),
        .ovf       (s_q.status),
        .load_o    (load_out),
        .valid_o   (load_valid),
        .busy_o    (div_busy)
    );

    always_comb begin
        s_d = s_q;
        if (reg_we && (reg_addr == ADDR_W'(REG_IRQ_EN))) begin
            s_d.irq_en = reg_wdata[0];
        end
        s_d.status = (s_q.status & ~(w1c | accept)) | (|thr_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < CNT_NUM; i++) begin
            if (reg_addr == ADDR_W'(i * REG_STRIDE + OFS_CTRL)) reg_rdata = DATA_W'(ctrl_v[i]);
            if (reg_addr == ADDR_W'(i * REG_STRIDE + OFS_MASK)) reg_rdata = DATA_W'(mask_v[i]);
            if (reg_addr == ADDR_W'(i * REG_STRIDE + OFS_THR))  reg_rdata = DATA_W'(thr_v[i]);
            if (reg_addr == ADDR_W'(i * REG_STRIDE + OFS_CNT))  reg_rdata = DATA_W'(cnt_v[i]);
        end
        if (reg_addr == ADDR_W'(REG_IRQ_EN)) reg_rdata = DATA_W'(s_q.irq_en);
        if (reg_addr == ADDR_W'(REG_STATUS)) reg_rdata = DATA_W'(s_q.status);
        if (reg_addr == ADDR_W'(REG_LOAD))   reg_rdata = DATA_W'(load_out);
    end

    assign irq = s_q.status & s_q.irq_en;

    // R3: the overflow flag is sticky without a clear
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.status && !accept && !w1c) |=> s_q.status);

    // R6: an accepted sample clears the flag when no threshold is reached
    a_r6_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(|thr_hit)) |=> !s_q.status);

    // R4: a write-one clear takes effect when no threshold is reached
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c && !(|thr_hit)) |=> !s_q.status);

    // R8: a result only appears while a divide was in flight
    a_r8_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_valid) |-> $past(div_busy));
endmodule

// File: tb/busy_load_monitor_tb.sv
module busy_load_monitor_tb;
    localparam int CNT_W   = 8;
    localparam int NUM_ENG = 4;
    localparam int NUM_W   = CNT_W + 10;
    localparam int CMAX    = (1 << CNT_W) - 1;
    localparam int TMAX    = (1 << (CNT_W - 1)) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  busy_in = '0;
    logic        sample_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  load_out;
    logic        load_valid;
    logic        irq;

    busy_load_monitor #(.CNT_W(CNT_W), .NUM_ENG(NUM_ENG)) u_dut (
        .clk(clk), .rst_n(rst_n), .busy_in(busy_in), .sample_req(sample_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .load_out(load_out), .load_valid(load_valid), .irq(irq)
    );

    always #10 clk = ~clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    int  m_cnt [2];
    int  m_mode [2];
    int  m_filt [2];
    int  m_mask [2];
    int  m_thr [2];
    bit  m_st, m_en;
    int  div_left;
    int  m_exp;
    int  p_cnt0, p_cnt1;
    bit  p_st, p_en;
    int  lv_seen, ld_seen, rd_seen;
    bit  irq_seen;
    logic [7:0] lfsr = 8'h5A;
    bit  g_use_fixed = 1'b0;
    logic [3:0] g_fixed = '0;

    task automatic check(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int expect_load(int b, int t, bit o);
        if (o || t == 0 || b > t) return 1000;
        return (b * 1000) / t;
    endfunction

    function automatic logic [3:0] next_pat();
        if (g_use_fixed) return g_fixed;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return lfsr[3:0];
    endfunction

    task automatic step(input logic [3:0] bv, input bit smp, input bit we,
                        input int addr, input int wd);
        int  inc [2];
        bit  set, acc, w1c, rst;
        @(negedge clk);
        lv_seen  = int'(load_valid);
        ld_seen  = int'(load_out);
        irq_seen = irq;
        busy_in    = bv;
        sample_req = smp;
        reg_we     = we;
        reg_addr   = 4'(addr);
        reg_wdata  = 32'(wd);
        #1;
        rd_seen = int'(reg_rdata);
        p_cnt0 = m_cnt[0];
        p_cnt1 = m_cnt[1];
        p_st   = m_st;
        p_en   = m_en;
        set = 1'b0;
        for (int i = 0; i < 2; i++) begin
            inc[i] = (m_mode[i] == 1 || (m_mode[i] == 2 && (int'(bv) & m_mask[i]) != 0)) ? 1 : 0;
            if (m_cnt[i] >= m_thr[i]) set = 1'b1;
        end
        acc = smp && (div_left == 0);
        w1c = we && addr == 9 && wd[0];
        if (acc) begin
            m_exp    = expect_load(m_cnt[1], m_cnt[0], m_st);
            div_left = NUM_W;
        end else if (div_left > 0) begin
            div_left--;
        end
        m_st = (m_st && !acc && !w1c) || set;
        for (int i = 0; i < 2; i++) begin
            rst = acc || (we && addr == i * 4 + 3 && wd[0]);
            if (rst) m_cnt[i] = inc[i];
            else if (m_cnt[i] + inc[i] > CMAX) m_cnt[i] = CMAX;
            else m_cnt[i] = m_cnt[i] + inc[i];
            if (we && addr == i * 4)     begin m_mode[i] = wd & 3; m_filt[i] = (wd >> 2) & 1; end
            if (we && addr == i * 4 + 1) m_mask[i] = wd & 15;
            if (we && addr == i * 4 + 2) m_thr[i] = wd & TMAX;
        end
        if (we && addr == 8) m_en = wd[0];
    endtask

    task automatic wr(input int addr, input int wd);
        step(next_pat(), 1'b0, 1'b1, addr, wd);
    endtask

    task automatic rd(input int addr);
        step(next_pat(), 1'b0, 1'b0, addr, 0);
    endtask

    task automatic run_window(input int extra, input int skip_at, input string rq);
        int e;
        step(next_pat(), 1'b1, 1'b0, 10, 0);
        e = m_exp;
        for (int i = 1; i <= NUM_W; i++) begin
            step(next_pat(), (i == skip_at), 1'b0, 10, 0);
            if (i == 1 || i == NUM_W) check("R8 early strobe", lv_seen, 0);
        end
        step(next_pat(), 1'b0, 1'b0, 10, 0);
        check("R8 strobe", lv_seen, 1);
        check(rq, ld_seen, e);
        check("R8 load word", rd_seen, e);
        for (int i = 0; i < extra; i++) step(next_pat(), 1'b0, 1'b0, 10, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_mode[i] = 0; m_filt[i] = 0; m_mask[i] = 0; m_thr[i] = TMAX;
        end
        m_st = 1'b0; m_en = 1'b0; div_left = 0; m_exp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(9);  check("R10 status", rd_seen, 0);
        check("R10 load_out", ld_seen, 0);
        check("R10 load_valid", lv_seen, 0);
        check("R10 irq", int'(irq_seen), 0);
        rd(2);  check("R10 threshold", rd_seen, TMAX);
        rd(0);  check("R10 control", rd_seen, 0);
        rd(3);  check("R10 count", rd_seen, 0);
        rd(8);  check("R10 enable", rd_seen, 0);

        // R11: configure, with the filter option set on counter 1
        wr(0, 1);
        wr(4, 2 | 4);
        wr(5, 5);
        rd(4);  check("R11 filter readback", rd_seen, 6);

        // R1 R6 R7 R9: sweep of window lengths with random busy patterns
        for (int x = 0; x <= 40; x++) begin
            run_window(x, (x % 4 == 1) ? 7 : 0, "R6 R7 sweep");
        end

        // R1: mask variants
        wr(5, 0);
        run_window(10, 0, "R1 empty mask");
        run_window(5, 0, "R1 empty mask");
        wr(5, 15);
        g_use_fixed = 1'b1; g_fixed = 4'hF;
        run_window(12, 0, "R1 all busy");
        run_window(3, 0, "R7 busy equals total");
        g_fixed = 4'h0;
        wr(5, 4'b1010);
        g_use_fixed = 1'b0;
        run_window(20, 0, "R1 partial mask");
        run_window(8, 0, "R1 partial mask");

        // R1: hold mode on the total counter gives total 0
        wr(0, 0);
        run_window(6, 0, "R1 hold");
        run_window(4, 0, "R7 total zero");
        rd(3);  check("R1 hold count", rd_seen, p_cnt0);
        wr(0, 1);

        // R2: restart by write, and a no-effect write
        wr(3, 2);
        rd(3);  check("R2 zero write", rd_seen, p_cnt0);
        wr(5, 15);
        g_use_fixed = 1'b1; g_fixed = 4'hF;
        run_window(20, 0, "R7 warmup");
        wr(3, 1);
        rd(3);  check("R2 restart", rd_seen, p_cnt0);
        check("R2 restart small", int'(rd_seen <= 2), 1);
        run_window(2, 0, "R7 busy over total");
        g_use_fixed = 1'b0;

        // R3 R5: overflow with interrupt off, then on
        wr(2, 30);
        for (int i = 0; i < 40; i++) step(next_pat(), 1'b0, 1'b0, 9, 0);
        rd(9);  check("R3 status set", rd_seen, 1);
        check("R3 status model", rd_seen, int'(p_st));
        check("R5 irq disabled", int'(irq_seen), 0);
        wr(8, 1);
        rd(9);  check("R5 irq enabled", int'(irq_seen), int'(p_st && p_en));
        check("R5 irq high", int'(irq_seen), 1);
        run_window(0, 0, "R7 overflow forces max");
        rd(9);  check("R6 status cleared", rd_seen, int'(p_st));
        check("R5 irq follows", int'(irq_seen), int'(p_st && p_en));

        // R4: write-one clear
        for (int i = 0; i < 20; i++) step(next_pat(), 1'b0, 1'b0, 9, 0);
        wr(2, TMAX);
        wr(9, 0);
        rd(9);  check("R4 zero write", rd_seen, 1);
        wr(9, 1);
        rd(9);  check("R4 clear", rd_seen, 0);
        check("R4 irq off", int'(irq_seen), 0);

        // R2 R3: saturation of the total counter
        wr(8, 0);
        for (int i = 0; i < 300; i++) step(4'h0, 1'b0, 1'b0, 3, 0);
        rd(3);  check("R2 saturate", rd_seen, CMAX);
        rd(9);  check("R3 status at saturation", rd_seen, 1);
        run_window(0, 0, "R7 saturated window");

        // R9: requests during the divide are ignored
        run_window(0, 3, "R9 window");
        for (int i = 0; i < NUM_W + 2; i++) begin
            step(next_pat(), 1'b0, 1'b0, 10, 0);
            check("R9 no extra strobe", lv_seen, 0);
        end
        run_window(2, 9, "R9 next window");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule